// File: doc/BRIEF.md
# Strobed Serial Configuration Port

This block receives a 20-bit control word over a three-wire, write-only serial link made of a shift clock, a data line and a framing strobe. The strobe rests high. A host pulls it low to open a frame, presents the bits on the data line most significant first, and raises the strobe again to commit the frame. All three serial lines are resynchronized into the system clock domain. Edges of the serial clock and of the strobe are then detected there, so the serial clock never clocks a flop directly.

A committed word is kept in a holding register. The decoded configuration fields come only from that register, and a motor bridge's chopping timer and drive logic read them. The fields are: blank-time code, fixed-off-time code, fast-decay-time code, synchronous-rectifier mode and enable, external-chop decay choice, enable and phase polarities, reference range select, internal decay choice, a test bit, and a wake bit. A frame that does not carry exactly twenty bits is thrown away. A level-sensitive undervoltage input clears the holding register to all zeros, which puts the bridge to sleep, and it also cancels any frame that is half-received.

Top module: `sercfg_port`

## Requirements
- R1: The data line is sampled on each rising edge of the serial clock seen while the strobe is low. The first bit shifted after the strobe falls ends up in bit 19 and the last bit ends up in bit 0.
- R2: Rising edges of the serial clock while the strobe is high leave the shift state unchanged and have no effect on the outputs.
- R3: When the strobe rises, the shifted word is copied into the holding register only if exactly 20 serial clock rising edges arrived during that low period. Frames with 19 edges or with 21 edges leave the outputs unchanged.
- R4: The outputs never change while a frame is being shifted in. They change only at a commit or at a clear.
- R5: The outputs decode the held word w as follows:
  - blank_code = w[1:0]
  - off_code = w[6:2]
  - fast_code = w[10:7]
  - sr_passive = w[11] (1 = passive, 0 = active)
  - sr_en = w[12]
  - ext_slow = w[13] (1 = slow, 0 = fast)
  - en_pol = w[14]
  - ph_pol = w[15]
  - range_sel = w[16]
  - int_mixed = w[17]
  - test_mode = w[18]
- R6: Reset, or uvlo held high for at least one clock, clears the holding register to zero and discards any partial frame.
- R7: sleep is high exactly when bit 19 of the held word is 0, so a cleared register means sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo | input | 1 | Synchronous undervoltage clear, active high |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data line (asynchronous) |
| ser_strobe | input | 1 | Frame strobe, idle high (asynchronous) |
| blank_code | output | 2 | Blanking time code |
| off_code | output | 5 | Fixed off-time code |
| fast_code | output | 4 | Fast-decay portion code |
| sr_passive | output | 1 | Synchronous rectifier passive mode |
| sr_en | output | 1 | Synchronous rectifier enable |
| ext_slow | output | 1 | Slow decay for external chopping |
| en_pol | output | 1 | Enable input polarity |
| ph_pol | output | 1 | Phase input polarity |
| range_sel | output | 1 | Reference divider select |
| int_mixed | output | 1 | Internal decay mixed select |
| test_mode | output | 1 | Test bit |
| sleep | output | 1 | Bridge asleep (wake bit low) |

## Verification
There are only two ways for a wrong internal state to reach the ports:
- A miscounted frame or a slipped shift shows up on the field outputs at the next strobe rising edge. It appears SYNC_STAGES+1 system clocks later, either as a word that is rotated or truncated, or as a word that should have been rejected.
- A decode or ordering error shows as a single output bit that disagrees with the frame.

The sweeps therefore commit walking-one and walking-zero words and arithmetic patterns, and compare every field at once. The holding register must also stay quiet during frames that are partial, oversized, idle or interrupted by undervoltage, so each of those cases is checked at the outputs before the next legal frame.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    localparam int WORD_W = 20;

    // Packed so that bit positions match the serial word, MSB = wake bit.
    typedef struct packed {
        logic       awake;
        logic       test_mode;
        logic       int_mixed;
        logic       range_sel;
        logic       ph_pol;
        logic       en_pol;
        logic       ext_slow;
        logic       sr_en;
        logic       sr_passive;
        logic [3:0] fast_code;
        logic [4:0] off_code;
        logic [1:0] blank_code;
    } cfg_fields_t;

endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
    parameter int           N       = 3,
    parameter int           STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    typedef struct packed {
        logic [STAGES-1:0][N-1:0] pipe;
        logic [N-1:0]             prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
        st_d.prev = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pipe <= {STAGES{RST_VAL}};
            st_q.prev <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl  = st_q.pipe[STAGES-1];
    assign rise = lvl & ~st_q.prev;
    assign fall = ~lvl & st_q.prev;

endmodule

// File: rtl/sercfg_shift.sv
module sercfg_shift #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         sclk_rise,
    input  logic         sdata,
    input  logic         strb_lvl,
    input  logic         strb_fall,
    input  logic         strb_rise,
    output logic [W-1:0] word,
    output logic         load
);

    localparam int              CNT_W    = $clog2(W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(W + 1);

    typedef struct packed {
        logic [W-1:0]     sreg;
        logic [CNT_W-1:0] cnt;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.sreg = '0;
            st_d.cnt  = '0;
        end else if (strb_fall) begin
            st_d.cnt = '0;
        end else if (sclk_rise && !strb_lvl) begin
            st_d.sreg = {st_q.sreg[W-2:0], sdata};
            if (st_q.cnt != CNT_OVER) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.sreg;
    assign load = strb_rise && !clr && (st_q.cnt == CNT_FULL);

    AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_lvl && !clr) |=> $stable(st_q.sreg)); // R2

    AST_CLR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !load); // R6

endmodule

// File: rtl/sercfg_hold.sv
module sercfg_hold
    import sercfg_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] word_in,
    output cfg_fields_t  fields
);

    typedef struct packed {
        logic [W-1:0] hold;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.hold = '0;
        end else if (load) begin
            st_d.hold = word_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fields = cfg_fields_t'(st_q.hold);

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr) |=> $stable(fields)); // R4

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fields == '0)); // R6

endmodule

// File: rtl/sercfg_port.sv
module sercfg_port
    import sercfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uvlo,
    input  logic       ser_clk,
    input  logic       ser_data,
    input  logic       ser_strobe,
    output logic [1:0] blank_code,
    output logic [4:0] off_code,
    output logic [3:0] fast_code,
    output logic       sr_passive,
    output logic       sr_en,
    output logic       ext_slow,
    output logic       en_pol,
    output logic       ph_pol,
    output logic       range_sel,
    output logic       int_mixed,
    output logic       test_mode,
    output logic       sleep
);

    localparam int LINES   = 3;
    localparam int IDX_CLK = 0;
    localparam int IDX_DAT = 1;
    localparam int IDX_STB = 2;

    logic [LINES-1:0] lvl, rise, fall;
    logic [WORD_W-1:0] shifted;
    logic             load;
    cfg_fields_t      fields;
    logic             unused_edges;

    sercfg_sync #(
        .N       (LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ser_strobe, ser_data, ser_clk}),
        .lvl   (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    assign unused_edges = ^{rise[IDX_DAT], fall[IDX_DAT], fall[IDX_CLK], lvl[IDX_CLK]};

    sercfg_shift #(
        .W (WORD_W)
    ) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (uvlo),
        .sclk_rise (rise[IDX_CLK]),
        .sdata     (lvl[IDX_DAT]),
        .strb_lvl  (lvl[IDX_STB]),
        .strb_fall (fall[IDX_STB]),
        .strb_rise (rise[IDX_STB]),
        .word      (shifted),
        .load      (load)
    );

    sercfg_hold #(
        .W (WORD_W)
    ) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (uvlo),
        .load    (load),
        .word_in (shifted),
        .fields  (fields)
    );

    assign blank_code = fields.blank_code;
    assign off_code   = fields.off_code;
    assign fast_code  = fields.fast_code;
    assign sr_passive = fields.sr_passive;
    assign sr_en      = fields.sr_en;
    assign ext_slow   = fields.ext_slow;
    assign en_pol     = fields.en_pol;
    assign ph_pol     = fields.ph_pol;
    assign range_sel  = fields.range_sel;
    assign int_mixed  = fields.int_mixed;
    assign test_mode  = fields.test_mode;
    assign sleep      = ~fields.awake;

    AST_UVLO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> sleep); // R7

    AST_LOAD_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (lvl[IDX_STB] && !uvlo)); // R3

endmodule

// File: tb/sercfg_port_tb.sv
`timescale 1ns/1ps
module sercfg_port_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uvlo = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_strobe = 1'b1;
    logic [1:0] blank_code;
    logic [4:0] off_code;
    logic [3:0] fast_code;
    logic sr_passive, sr_en, ext_slow, en_pol, ph_pol, range_sel;
    logic int_mixed, test_mode, sleep;

    int vectors = 0;
    int miscompares = 0;
    logic [19:0] current = '0;

    always #2.5 clk = ~clk;

    sercfg_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .uvlo       (uvlo),
        .ser_clk    (ser_clk),
        .ser_data   (ser_data),
        .ser_strobe (ser_strobe),
        .blank_code (blank_code),
        .off_code   (off_code),
        .fast_code  (fast_code),
        .sr_passive (sr_passive),
        .sr_en      (sr_en),
        .ext_slow   (ext_slow),
        .en_pol     (en_pol),
        .ph_pol     (ph_pol),
        .range_sel  (range_sel),
        .int_mixed  (int_mixed),
        .test_mode  (test_mode),
        .sleep      (sleep)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift nclk bits of w, MSB first; extra bits beyond 20 are zero.
    task automatic send(input logic [19:0] w, input int nclk);
        ser_strobe = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nclk; i++) begin
            ser_data = (i < 20) ? w[19-i] : 1'b0;
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        wait_clk(4);
        ser_strobe = 1'b1;
        wait_clk(6);
    endtask

    function automatic logic [19:0] observed();
        return {~sleep, test_mode, int_mixed, range_sel, ph_pol, en_pol,
                ext_slow, sr_en, sr_passive, fast_code, off_code, blank_code};
    endfunction

    task automatic check(input logic [19:0] exp, input string req);
        logic [19:0] got;
        got = observed();
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: fields got %05h expected %05h", req, got, exp);
        end
        vectors++;
        if (sleep !== ~exp[19]) begin
            miscompares++;
            $display("FAIL R7: sleep got %0b expected %0b", sleep, ~exp[19]);
        end
    endtask

    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        wait_clk(3);
        check(20'h0, "R6 reset");
        rst_n = 1'b1;
        wait_clk(3);
        check(20'h0, "R6 after reset");

        // R1 R5: walking ones and zeros over every bit position
        for (int b = 0; b < 20; b++) begin
            current = 20'h1 << b;
            send(current, 20);
            check(current, "R1/R5 walking one");
        end
        for (int b = 0; b < 20; b++) begin
            current = ~(20'h1 << b);
            send(current, 20);
            check(current, "R1/R5 walking zero");
        end
        // arithmetic patterns
        for (int k = 1; k <= 12; k++) begin
            current = 20'((k * 32'h2F3A7) ^ (k << 13));
            send(current, 20);
            check(current, "R5 pattern");
        end

        // R3: short and long frames are discarded
        current = 20'hA5C3E;
        send(current, 20);
        check(current, "R3 baseline");
        send(20'h5A3C1, 19);
        check(current, "R3 19 clocks");
        send(20'h5A3C1, 21);
        check(current, "R3 21 clocks");
        send(20'h0, 0);
        check(current, "R3 empty frame");

        // R2: clock activity with strobe high
        for (int i = 0; i < 6; i++) begin
            ser_data = i[0];
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        wait_clk(6);
        check(current, "R2 idle clocks");
        send(20'h80001, 20);
        current = 20'h80001;
        check(current, "R2 frame after idle clocks");

        // R4: outputs steady mid-frame
        ser_strobe = 1'b0;
        wait_clk(4);
        for (int i = 0; i < 10; i++) begin
            ser_data = 1'b1;
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        wait_clk(2);
        check(current, "R4 mid frame");

        // R6: undervoltage mid-frame clears and aborts
        uvlo = 1'b1;
        wait_clk(2);
        uvlo = 1'b0;
        wait_clk(1);
        check(20'h0, "R6 uvlo clear");
        for (int i = 0; i < 10; i++) begin
            ser_data = 1'b1;
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        wait_clk(4);
        ser_strobe = 1'b1;
        wait_clk(6);
        check(20'h0, "R6 aborted frame");

        current = 20'hFFFFF;
        send(current, 20);
        check(current, "R5 all ones");
        current = 20'h7FFFF;
        send(current, 20);
        check(current, "R7 sleep with fields set");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule